// File: doc/BRIEF.md
# Vertical-Sync-Clocked Display Identification Transmitter

This block sends a display's identification bytes to a video controller over an open-drain serial data line, with the controller's vertical-sync output serving as the bit clock. Software writes one byte at a time into a holding register. Each rising vertical-sync edge moves one bit onto the line, most significant bit first. A ninth bit time with the line released ends each byte. While the mode is enabled the stream never stops. If software has not supplied a new byte by the time a frame begins, the last byte is sent again.

The block also watches the serial clock line. A falling edge on that line shows that a host wants addressed two-wire communication. It sets a sticky flag, which can interrupt the CPU so that software can hand the pins to the addressed protocol engine. Both asynchronous inputs pass through synchronisers before their edges are detected. The data pin is never driven high: the block only enables a pull-low.

Top module: `ddc1_tx`

## Requirements
- R1: After reset the data line is released (sda_oe_o=0), empty_o=1, scl_flag_o=0, and irq_o=0 while no interrupt enable is set.
- R2: While en_i=1, each rising edge of vsync_i puts one bit of the current byte on the line, most significant bit first. A 0 bit gives sda_oe_o=1 (pull low) and a 1 bit gives sda_oe_o=0 (released).
- R3: The ninth bit time of every frame releases the line (sda_oe_o=0). The next vsync_i rising edge starts the next frame with its most significant bit.
- R4: At the first bit of a frame, the holding register moves into the shift register and empty_o becomes 1. A pulse on wr_i loads wdata_i into the holding register and clears empty_o.
- R5: When no write arrives during a frame, the next frame sends the same byte again.
- R6: Driving en_i low releases the line in the same cycle and resets the bit position. The first vsync_i rising edge after re-enabling sends the most significant bit of the held byte.
- R7: The data pin is only ever pulled low, and only while en_i=1.
- R8: A falling edge on scl_i while en_i=1 sets scl_flag_o. A falling edge while en_i=0 is ignored.
- R9: scl_flag_o stays set until a pulse on scl_clr_i clears it.
- R10: irq_o is 1 exactly when (empty_o and empty_ie_i) or (scl_flag_o and scl_ie_i).
- R11: Each asynchronous input passes through a two-flop synchroniser. sda_oe_o changes on the third clk_i rising edge after the vsync_i change, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Transmit mode enable |
| wr_i | input | 1 | Holding register write strobe |
| wdata_i | input | DW | Byte to be sent |
| empty_ie_i | input | 1 | Interrupt enable for buffer-empty |
| scl_ie_i | input | 1 | Interrupt enable for clock-line edge |
| scl_clr_i | input | 1 | Write-1 strobe clearing the clock-line edge flag |
| vsync_i | input | 1 | Vertical-sync bit clock, asynchronous |
| scl_i | input | 1 | Serial clock line level, asynchronous |
| sda_oe_o | output | 1 | Pull-low enable for the open-drain data pin |
| empty_o | output | 1 | Holding register free for a new byte |
| scl_flag_o | output | 1 | Clock-line falling edge seen |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with the defaults: an 8-bit byte and two synchroniser stages. At that width every byte value 0x00 to 0xFF can be streamed back to back, so each bit position, the released ninth bit and each holding-register handover are checked for every value, with the expected pin level taken from the byte's own bits. The small frame also makes it cheap to reach a frame that repeats because no write arrived, a disable in the middle of a frame, and clock-line edges in both enable states.

// File: rtl/ddc1_pkg.sv
package ddc1_pkg;
  localparam int unsigned DDC1_DW      = 8;
  localparam int unsigned DDC1_SYNC_N  = 2;

  function automatic int unsigned cnt_width(input int unsigned dw);
    return $clog2(dw + 1);
  endfunction
endpackage

// File: rtl/ddc1_sync_edge.sv
module ddc1_sync_edge #(
  parameter int unsigned STAGES  = ddc1_pkg::DDC1_SYNC_N,
  parameter bit          RST_VAL = 1'b0,
  parameter bit          FALL    = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic edge_o
);
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= {(STAGES+1){RST_VAL}};
    else         pipe_q <= {pipe_q[STAGES-1:0], async_i};
  end

  // pipe_q[STAGES-1] is the synchronised level, pipe_q[STAGES] its previous value
  generate
    if (FALL) begin : g_fall
      assign edge_o = !pipe_q[STAGES-1] && pipe_q[STAGES];
    end else begin : g_rise
      assign edge_o = pipe_q[STAGES-1] && !pipe_q[STAGES];
    end
  endgenerate
endmodule

// File: rtl/ddc1_shifter.sv
module ddc1_shifter #(
  parameter int unsigned DW = ddc1_pkg::DDC1_DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          tick_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          drive_low_o,
  output logic          empty_o
);
  localparam int unsigned CW = ddc1_pkg::cnt_width(DW);

  logic [DW-1:0] hold_q, shift_q;
  logic [CW-1:0] cnt_q;
  logic          drive_q, empty_q;
  logic          first, last;

  assign first = (cnt_q == '0);
  assign last  = (cnt_q == CW'(DW));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q  <= '1;
      shift_q <= '1;
      cnt_q   <= '0;
      drive_q <= 1'b0;
    end else begin
      if (wr_i) hold_q <= wdata_i;
      if (!en_i) begin
        cnt_q   <= '0;
        drive_q <= 1'b0;
      end else if (tick_i) begin
        if (first) begin
          drive_q <= ~hold_q[DW-1];
          shift_q <= {hold_q[DW-2:0], 1'b1};
          cnt_q   <= CW'(1);
        end else if (last) begin
          drive_q <= 1'b0;          // framing bit: line released
          cnt_q   <= '0;
        end else begin
          drive_q <= ~shift_q[DW-1];
          shift_q <= {shift_q[DW-2:0], 1'b1};
          cnt_q   <= cnt_q + CW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          empty_q <= 1'b1;
    else if (wr_i)                        empty_q <= 1'b0;
    else if (en_i && tick_i && first)     empty_q <= 1'b1;
  end

  assign drive_low_o = drive_q;
  assign empty_o     = empty_q;

  assert_cnt_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DW));
  assert_ninth_release_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && last) |=> (!drive_q && cnt_q == '0));
  assert_empty_on_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && first && !wr_i) |=> empty_q);
  assert_write_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> !empty_q);
  assert_disable_resets_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!drive_q && cnt_q == '0));
endmodule

// File: rtl/ddc1_irq.sv
module ddc1_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic scl_fall_i,
  input  logic scl_clr_i,
  input  logic empty_i,
  input  logic empty_ie_i,
  input  logic scl_ie_i,
  output logic scl_flag_o,
  output logic irq_o
);
  logic flag_q;

  // a new edge wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   flag_q <= 1'b0;
    else if (scl_fall_i && en_i)   flag_q <= 1'b1;
    else if (scl_clr_i)            flag_q <= 1'b0;
  end

  assign scl_flag_o = flag_q;
  assign irq_o      = (empty_i && empty_ie_i) || (flag_q && scl_ie_i);

  assert_fall_sets_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_fall_i && en_i) |=> flag_q);
  assert_flag_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !scl_clr_i) |=> flag_q);
  assert_flag_needs_edge_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_q && !(scl_fall_i && en_i)) |=> !flag_q);
endmodule

// File: rtl/ddc1_tx.sv
module ddc1_tx #(
  parameter int unsigned DW     = ddc1_pkg::DDC1_DW,
  parameter int unsigned SYNC_N = ddc1_pkg::DDC1_SYNC_N
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          empty_ie_i,
  input  logic          scl_ie_i,
  input  logic          scl_clr_i,
  input  logic          vsync_i,
  input  logic          scl_i,
  output logic          sda_oe_o,
  output logic          empty_o,
  output logic          scl_flag_o,
  output logic          irq_o
);
  logic vs_rise, scl_fall, drive_low, empty;

  ddc1_sync_edge #(.STAGES(SYNC_N), .RST_VAL(1'b0), .FALL(1'b0)) u_vs_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(vsync_i), .edge_o(vs_rise));

  ddc1_sync_edge #(.STAGES(SYNC_N), .RST_VAL(1'b1), .FALL(1'b1)) u_scl_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(scl_i), .edge_o(scl_fall));

  ddc1_shifter #(.DW(DW)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .tick_i(vs_rise),
    .wr_i(wr_i), .wdata_i(wdata_i), .drive_low_o(drive_low), .empty_o(empty));

  ddc1_irq u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .scl_fall_i(scl_fall),
    .scl_clr_i(scl_clr_i), .empty_i(empty), .empty_ie_i(empty_ie_i),
    .scl_ie_i(scl_ie_i), .scl_flag_o(scl_flag_o), .irq_o(irq_o));

  // open drain: only a pull-low enable, gated so disable releases at once
  assign sda_oe_o = drive_low && en_i;
  assign empty_o  = empty;

  assert_pull_only_enabled_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_oe_o |-> en_i);
  assert_pin_moves_on_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && !$past(vs_rise)) |-> $stable(sda_oe_o));
endmodule

// File: tb/ddc1_tx_tb.sv
module ddc1_tx_tb;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en = 1'b0, wr = 1'b0, empty_ie = 1'b0, scl_ie = 1'b0, scl_clr = 1'b0;
  logic vsync = 1'b0, scl = 1'b1;
  logic [DW-1:0] wdata = '0;
  logic sda_oe, empty, scl_flag, irq;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ddc1_tx #(.DW(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .wr_i(wr), .wdata_i(wdata),
    .empty_ie_i(empty_ie), .scl_ie_i(scl_ie), .scl_clr_i(scl_clr),
    .vsync_i(vsync), .scl_i(scl), .sda_oe_o(sda_oe), .empty_o(empty),
    .scl_flag_o(scl_flag), .irq_o(irq));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    vsync = 1'b1;
    repeat (4) @(negedge clk);
    vsync = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic write(input logic [DW-1:0] d);
    wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic exp_bit(input logic [DW-1:0] v, input int b);
    return (b < DW) ? ~v[DW-1-b] : 1'b0;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 sda", sda_oe, 1'b0);
    chk("R1 empty", empty, 1'b1);
    chk("R1 flag", scl_flag, 1'b0);
    chk("R1 irq", irq, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk);
    en = 1'b1;
    write(8'h00);
    chk("R4 write clears empty", empty, 1'b0);

    // R11 synchroniser latency: 0x00 gives bit0 pull-low
    vsync = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R11 no change after two edges", sda_oe, 1'b0);
    @(negedge clk);
    chk("R11 change on third edge", sda_oe, 1'b1);
    @(negedge clk);
    vsync = 1'b0;
    repeat (4) @(negedge clk);
    for (int b = 1; b <= DW; b++) tick();

    // R2 R3 R4 sweep of all byte values, back to back
    write(8'h00);
    for (int v = 0; v < 256; v++) begin
      for (int b = 0; b <= DW; b++) begin
        tick();
        if (b == 0) begin
          chk("R4 empty on load", empty, 1'b1);
          if (v < 255) write(DW'(v + 1));
        end
        if (b == DW) chk("R3 ninth bit released", sda_oe, exp_bit(DW'(v), b));
        else         chk("R2 data bit", sda_oe, exp_bit(DW'(v), b));
      end
    end

    // R5 no refill: 0xFF was last, now load 0x5A then let it repeat
    write(8'h5A);
    for (int f = 0; f < 2; f++)
      for (int b = 0; b <= DW; b++) begin
        tick();
        chk("R5 repeated frame", sda_oe, exp_bit(8'h5A, b));
      end

    // R6 disable mid-frame with 0x00 (line pulled low)
    write(8'h00);
    for (int b = 0; b < 3; b++) tick();
    chk("R6 low before disable", sda_oe, 1'b1);
    en = 1'b0;
    #1;
    chk("R6 released same cycle", sda_oe, 1'b0);
    chk("R7 no pull while disabled", sda_oe, 1'b0);
    tick();
    chk("R7 tick ignored while disabled", sda_oe, 1'b0);
    write(8'h3C);
    en = 1'b1;
    tick();
    chk("R6 restart at msb", sda_oe, exp_bit(8'h3C, 0));
    tick();
    chk("R6 second bit", sda_oe, exp_bit(8'h3C, 1));

    // R10 empty interrupt
    chk("R10 irq off without enable", irq, 1'b0);
    empty_ie = 1'b1;
    #1;
    chk("R10 empty irq", irq, 1'b1);
    empty_ie = 1'b0;

    // R8 clock edge ignored when disabled
    en = 1'b0;
    scl = 1'b0;
    repeat (5) @(negedge clk);
    chk("R8 ignored when disabled", scl_flag, 1'b0);
    scl = 1'b1;
    repeat (5) @(negedge clk);
    en = 1'b1;
    scl = 1'b0;
    repeat (5) @(negedge clk);
    chk("R8 flag set on fall", scl_flag, 1'b1);
    scl = 1'b1;
    repeat (10) @(negedge clk);
    chk("R9 flag sticky", scl_flag, 1'b1);
    chk("R10 irq off with scl_ie=0", irq, 1'b0);
    scl_ie = 1'b1;
    #1;
    chk("R10 scl irq", irq, 1'b1);
    scl_clr = 1'b1;
    @(negedge clk);
    scl_clr = 1'b0;
    @(negedge clk);
    chk("R9 cleared by write", scl_flag, 1'b0);
    chk("R10 irq drops", irq, 1'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule